// File: doc/BRIEF.md
# Grouped Vectored Interrupt Controller

This block sits beside a small microcontroller core and decides which interrupt vector the core is asked to take. Three direct fault sources (over-voltage, over-current and a short on a high-voltage pin) each latch into a request flag of their own. Each timer has two compare-match events, A and P. These land in member flags, and the members of one timer form a multi-function group with its own group flag and group enable.

A request reaches the core only when the global enable is on, the relevant enables are on, and the core reports that its return stack has room. The lowest pending vector wins. The core answers with a one-cycle acknowledge that carries the serviced vector. On that acknowledge the global enable drops, and a serviced direct flag clears itself. A serviced group clears only its group flag, and the member flags stay set until software clears them. Any flag rising from 0 to 1 also raises a wake pulse, whatever the enables hold.

Software reaches all flags and enables through a small register window with a write strobe and a combinational read port.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset every flag and every enable reads 0, and `irq_req` and `wake` are 0.
- R2: A high level on `ev_ov`, `ev_oc` or `ev_sc` at a clock edge sets direct flag bit 0, 1 or 2 respectively. The flag reads 1 from that edge on.
- R3: A direct source is pending only if the global enable, that source's enable and its flag are all 1.
- R4: While `stack_full` is 1, `irq_req` is 0.
- R5: Vectors are numbered as follows: over-voltage 0, over-current 1, short-circuit 2, and group g is 3+g. When `irq_req` is 1, `irq_vec` holds the lowest pending vector.
- R6: An acknowledge (`ack`=1) clears the global enable at that edge. If `ack_vec` is 0, 1 or 2, the matching direct flag is cleared too.
- R7: A timer event sets its member flag whatever the enables hold. The group flag of that timer is set when a member event arrives while that member's enable is 1. A group is pending only if the global enable, the group enable, the group flag, and at least one member whose flag and enable are both 1 are all present.
- R8: An acknowledge of vector 3+g clears group flag g and leaves every member flag unchanged.
- R9: When a source event and a clear of the same flag (software write of 0 or acknowledge) fall on the same edge, the flag ends up 1.
- R10: `wake` is 1 for exactly the cycle after any flag (direct, member or group) goes from 0 to 1, whatever the enables hold. A flag that is already set does not raise it again.
- R11: The register window, selected by `sw_addr` and read on `sw_rdata` with unused bits reading 0, is laid out as follows. Address 0 holds the global enable in bit 0. Address 1 holds the direct enables and address 2 the direct flags, both in bits 2:0. Address 3 holds the group enables and address 4 the group flags, bit g for timer g. Address 5 holds the member enables and address 6 the member flags, with bit 2t for match A and bit 2t+1 for match P of timer t. A write with `sw_we`=1 takes effect at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_ov | input | 1 | Over-voltage detector event |
| ev_oc | input | 1 | Over-current detector event |
| ev_sc | input | 1 | High-voltage pin short event |
| tmr_match_a | input | NT | Compare-match A event, one bit per timer |
| tmr_match_p | input | NT | Compare-match P event, one bit per timer |
| stack_full | input | 1 | Core return stack has no free entry |
| ack | input | 1 | One-cycle service acknowledge from the core |
| ack_vec | input | VW | Vector being serviced |
| sw_we | input | 1 | Register write strobe |
| sw_addr | input | 3 | Register select |
| sw_wdata | input | DW | Register write data |
| sw_rdata | output | DW | Register read data for `sw_addr` |
| irq_req | output | 1 | Vector request to the core |
| irq_vec | output | VW | Requested vector, valid while `irq_req` is 1 |
| wake | output | 1 | Wake-up pulse on any new flag |

## Verification
The direct path is tried over every combination of global enable, the three source enables, the three flags and the stack-full input. This separates enable gating from priority order and from stack blocking. The grouped path is swept over all group enables, member enables, member flags and group flags of two timers. This shows that a group flag alone, or a set member that is not enabled, never requests, and that the lower group wins. Directed sequences then drive real detector and timer events and acknowledges. They tell apart self-clearing of direct flags, group-only clearing, event-over-clear resolution, and wake pulses on new flags as opposed to flags that are already set.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  localparam int unsigned NUM_DIRECT = 3;

  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_DEN   = 3'd1;
  localparam logic [2:0] A_DFLAG = 3'd2;
  localparam logic [2:0] A_GEN   = 3'd3;
  localparam logic [2:0] A_GFLAG = 3'd4;
  localparam logic [2:0] A_MEN   = 3'd5;
  localparam logic [2:0] A_MFLAG = 3'd6;

  // event beats clear, clear beats software write
  function automatic logic flag_next(logic cur, logic set, logic clr,
                                     logic wr, logic wv);
    if (set)      return 1'b1;
    else if (clr) return 1'b0;
    else if (wr)  return wv;
    else          return cur;
  endfunction

endpackage

// File: rtl/irq_direct_bank.sv
module irq_direct_bank #(
  parameter int ND = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [ND-1:0] ev,
  input  logic [ND-1:0] clr,
  input  logic          we_flag,
  input  logic          we_en,
  input  logic [ND-1:0] wv,
  output logic [ND-1:0] flag,
  output logic [ND-1:0] en
);
  import irq_vec_pkg::*;

  logic [ND-1:0] flag_d, en_d;

  always_comb begin
    for (int i = 0; i < ND; i++)
      flag_d[i] = flag_next(flag[i], ev[i], clr[i], we_flag, wv[i]);
    en_d = we_en ? wv : en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= '0;
      en   <= '0;
    end else begin
      flag <= flag_d;
      en   <= en_d;
    end
  end
endmodule

// File: rtl/irq_group_slice.sv
module irq_group_slice (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ev,
  input  logic       ack_hit,
  input  logic       we_men,
  input  logic       we_mflag,
  input  logic       we_gen,
  input  logic       we_gflag,
  input  logic [1:0] wv_m,
  input  logic       wv_g,
  output logic [1:0] mflag,
  output logic [1:0] men,
  output logic       gen,
  output logic       gflag,
  output logic       armed
);
  import irq_vec_pkg::*;

  logic [1:0] mflag_d, men_d;
  logic       gen_d, gflag_d, grp_set;

  always_comb begin
    grp_set = |(ev & men);
    for (int j = 0; j < 2; j++)
      mflag_d[j] = flag_next(mflag[j], ev[j], 1'b0, we_mflag, wv_m[j]);
    gflag_d = flag_next(gflag, grp_set, ack_hit, we_gflag, wv_g);
    men_d   = we_men ? wv_m : men;
    gen_d   = we_gen ? wv_g : gen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mflag <= '0;
      men   <= '0;
      gen   <= 1'b0;
      gflag <= 1'b0;
    end else begin
      mflag <= mflag_d;
      men   <= men_d;
      gen   <= gen_d;
      gflag <= gflag_d;
    end
  end

  assign armed = gen & gflag & (|(mflag & men));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 5,
  parameter int VW = 3
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [VW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--)
      if (pend[i]) idx = VW'(i);
    any = |pend;
  end
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl #(
  parameter  int NT = 2,
  localparam int NV = 3 + NT,
  localparam int VW = $clog2(NV),
  localparam int DW = (2 * NT > 3) ? 2 * NT : 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_ov,
  input  logic          ev_oc,
  input  logic          ev_sc,
  input  logic [NT-1:0] tmr_match_a,
  input  logic [NT-1:0] tmr_match_p,
  input  logic          stack_full,
  input  logic          ack,
  input  logic [VW-1:0] ack_vec,
  input  logic          sw_we,
  input  logic [2:0]    sw_addr,
  input  logic [DW-1:0] sw_wdata,
  output logic [DW-1:0] sw_rdata,
  output logic          irq_req,
  output logic [VW-1:0] irq_vec,
  output logic          wake
);
  import irq_vec_pkg::*;

  localparam int ND = NUM_DIRECT;
  localparam int NF = ND + 3 * NT;

  logic [ND-1:0]   dflag, den, dclr;
  logic [2*NT-1:0] mflag, men;
  logic [NT-1:0]   gflag, gen, garmed, gclr;
  logic            gie, gie_d, any_pend;
  logic [NV-1:0]   pend;
  logic [NF-1:0]   flags_all, flags_q;

  // global enable
  always_comb begin
    gie_d = gie;
    if (ack)
      gie_d = 1'b0;
    else if (sw_we && sw_addr == A_CTRL)
      gie_d = sw_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gie <= 1'b0;
    else        gie <= gie_d;
  end

  // direct sources
  for (genvar i = 0; i < ND; i++) begin : g_dclr
    assign dclr[i] = ack && (ack_vec == VW'(i));
  end

  irq_direct_bank #(.ND(ND)) u_direct (
    .clk     (clk),
    .rst_n   (rst_n),
    .ev      ({ev_sc, ev_oc, ev_ov}),
    .clr     (dclr),
    .we_flag (sw_we && sw_addr == A_DFLAG),
    .we_en   (sw_we && sw_addr == A_DEN),
    .wv      (sw_wdata[ND-1:0]),
    .flag    (dflag),
    .en      (den)
  );

  // one multi-function group per timer
  for (genvar g = 0; g < NT; g++) begin : g_grp
    assign gclr[g] = ack && (ack_vec == VW'(ND + g));

    irq_group_slice u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .ev       ({tmr_match_p[g], tmr_match_a[g]}),
      .ack_hit  (gclr[g]),
      .we_men   (sw_we && sw_addr == A_MEN),
      .we_mflag (sw_we && sw_addr == A_MFLAG),
      .we_gen   (sw_we && sw_addr == A_GEN),
      .we_gflag (sw_we && sw_addr == A_GFLAG),
      .wv_m     (sw_wdata[2*g+1:2*g]),
      .wv_g     (sw_wdata[g]),
      .mflag    (mflag[2*g+1:2*g]),
      .men      (men[2*g+1:2*g]),
      .gen      (gen[g]),
      .gflag    (gflag[g]),
      .armed    (garmed[g])
    );
  end

  // request and priority
  assign pend = {garmed, (dflag & den)} & {NV{gie}};

  irq_prio_enc #(.N(NV), .VW(VW)) u_prio (
    .pend (pend),
    .any  (any_pend),
    .idx  (irq_vec)
  );

  assign irq_req = any_pend & ~stack_full;

  // wake on any new flag
  assign flags_all = {gflag, mflag, dflag};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_all;
  end

  assign wake = |(flags_all & ~flags_q);

  // software read port
  always_comb begin
    case (sw_addr)
      A_CTRL:  sw_rdata = DW'(gie);
      A_DEN:   sw_rdata = DW'(den);
      A_DFLAG: sw_rdata = DW'(dflag);
      A_GEN:   sw_rdata = DW'(gen);
      A_GFLAG: sw_rdata = DW'(gflag);
      A_MEN:   sw_rdata = DW'(men);
      A_MFLAG: sw_rdata = DW'(mflag);
      default: sw_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_vector_ctrl_chk.sv
module irq_vector_ctrl_chk #(
  parameter int NT = 2,
  parameter int VW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ev_ov,
  input logic          ack,
  input logic [VW-1:0] ack_vec,
  input logic          stack_full,
  input logic          irq_req,
  input logic [VW-1:0] irq_vec,
  input logic          wake,
  input logic          gie,
  input logic          dflag_ov,
  input logic          den_ov,
  input logic [2*NT-1:0] mflag,
  input logic          sw_we,
  input logic [2:0]    sw_addr
);
  import irq_vec_pkg::*;

  p_req_needs_gie_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> gie);

  p_stack_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stack_full |-> !irq_req);

  p_prio_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && dflag_ov && den_ov) |-> (irq_vec == '0));

  p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ack_vec == '0 && !ev_ov) |=> (!dflag_ov && !gie));

  p_member_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !(sw_we && sw_addr == A_MFLAG)) |=>
      ((mflag & $past(mflag)) == $past(mflag)));

  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ov |=> dflag_ov);

  p_wake_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dflag_ov) |-> wake);
endmodule

bind irq_vector_ctrl irq_vector_ctrl_chk #(.NT(NT), .VW(VW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ev_ov      (ev_ov),
  .ack        (ack),
  .ack_vec    (ack_vec),
  .stack_full (stack_full),
  .irq_req    (irq_req),
  .irq_vec    (irq_vec),
  .wake       (wake),
  .gie        (gie),
  .dflag_ov   (dflag[0]),
  .den_ov     (den[0]),
  .mflag      (mflag),
  .sw_we      (sw_we),
  .sw_addr    (sw_addr)
);

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/100ps
module sim_irq_vector_ctrl;
  localparam int NT = 2;
  localparam int VW = 3;
  localparam int DW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ev_ov, ev_oc, ev_sc, stack_full, ack, sw_we, irq_req, wake;
  logic [NT-1:0] tmr_match_a, tmr_match_p;
  logic [VW-1:0] ack_vec, irq_vec;
  logic [2:0]    sw_addr;
  logic [DW-1:0] sw_wdata, sw_rdata;

  irq_vector_ctrl #(.NT(NT)) u0 (
    .clk(clk), .rst_n(rst_n), .ev_ov(ev_ov), .ev_oc(ev_oc), .ev_sc(ev_sc),
    .tmr_match_a(tmr_match_a), .tmr_match_p(tmr_match_p),
    .stack_full(stack_full), .ack(ack), .ack_vec(ack_vec),
    .sw_we(sw_we), .sw_addr(sw_addr), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata), .irq_req(irq_req), .irq_vec(irq_vec), .wake(wake)
  );

  int errs = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic wr(int a, int d);
    sw_we = 1'b1; sw_addr = 3'(a); sw_wdata = DW'(d);
    tick;
    sw_we = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    sw_addr = 3'(a);
    #0.1;
    v = int'(sw_rdata);
  endtask

  task automatic clear_all;
    for (int a = 0; a < 7; a++) wr(a, 0);
    tick;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary;
    end
  end

  initial begin
    int v, exp_vec;
    bit exp_req;
    rst_n = 0; ev_ov = 0; ev_oc = 0; ev_sc = 0; stack_full = 0; ack = 0;
    ack_vec = '0; sw_we = 0; sw_addr = '0; sw_wdata = '0;
    tmr_match_a = '0; tmr_match_p = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    tick;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a, v); chk("R1 register after reset", v, 0);
    end
    chk("R1 irq_req after reset", int'(irq_req), 0);
    chk("R1 wake after reset", int'(wake), 0);

    // R11 readback of enables
    wr(1, 7); rd(1, v); chk("R11 direct enables", v, 7);
    wr(5, 15); rd(5, v); chk("R11 member enables", v, 15);
    wr(3, 3); rd(3, v); chk("R11 group enables", v, 3);
    wr(0, 1); rd(0, v); chk("R11 global enable", v, 1);
    wr(7, 15); rd(7, v); chk("R11 unmapped reads 0", v, 0);
    clear_all;

    // R3 R4 R5 direct sweep
    for (int ge = 0; ge < 2; ge++)
      for (int de = 0; de < 8; de++)
        for (int fl = 0; fl < 8; fl++)
          for (int sf = 0; sf < 2; sf++) begin
            int p;
            wr(0, ge); wr(1, de); wr(2, fl);
            stack_full = sf[0];
            #0.1;
            p = (ge != 0) ? (de & fl) : 0;
            exp_req = (p != 0) && (sf == 0);
            exp_vec = 0;
            for (int b = 2; b >= 0; b--) if (p[b]) exp_vec = b;
            chk("R3 R4 direct request", int'(irq_req), int'(exp_req));
            if (exp_req) chk("R5 direct priority", int'(irq_vec), exp_vec);
          end
    stack_full = 0;
    clear_all;

    // R7 R5 group sweep
    wr(0, 1);
    for (int ge = 0; ge < 4; ge++)
      for (int me = 0; me < 16; me++)
        for (int mf = 0; mf < 16; mf++)
          for (int gf = 0; gf < 4; gf++) begin
            int p;
            wr(3, ge); wr(5, me); wr(6, mf); wr(4, gf);
            #0.1;
            p = 0;
            for (int g = 0; g < NT; g++)
              if (ge[g] && gf[g] && (((mf & me) >> (2 * g)) & 3) != 0) p |= (1 << g);
            exp_req = (p != 0);
            exp_vec = 0;
            for (int g = NT - 1; g >= 0; g--) if (p[g]) exp_vec = 3 + g;
            chk("R7 group request", int'(irq_req), int'(exp_req));
            if (exp_req) chk("R5 group priority", int'(irq_vec), exp_vec);
          end
    // R5 direct beats group
    wr(1, 4); wr(2, 4);
    chk("R5 short-circuit over group", int'(irq_vec), 2);
    clear_all;

    // R2 R10 detector events with global enable off
    ev_ov = 1; tick; ev_ov = 0;
    rd(2, v); chk("R2 over-voltage flag", v, 1);
    chk("R10 wake on new flag", int'(wake), 1);
    tick; chk("R10 wake lasts one cycle", int'(wake), 0);
    ev_ov = 1; tick; ev_ov = 0;
    chk("R10 no wake for set flag", int'(wake), 0);
    ev_oc = 1; tick; ev_oc = 0;
    rd(2, v); chk("R2 over-current flag", v, 3);
    ev_sc = 1; tick; ev_sc = 0;
    rd(2, v); chk("R2 short-circuit flag", v, 7);
    clear_all;

    // R6 acknowledge of direct vector
    wr(0, 1); wr(1, 7);
    ev_ov = 1; ev_oc = 1; tick; ev_ov = 0; ev_oc = 0;
    #0.1;
    chk("R6 request before ack", int'(irq_req), 1);
    chk("R5 vector before ack", int'(irq_vec), 0);
    ack = 1; ack_vec = 3'd0; tick; ack = 0;
    rd(2, v); chk("R6 serviced flag cleared", v, 2);
    rd(0, v); chk("R6 global enable cleared", v, 0);
    chk("R6 no request after ack", int'(irq_req), 0);
    wr(0, 1); #0.1;
    chk("R6 next vector", int'(irq_vec), 1);

    // R9 event versus clear
    sw_we = 1; sw_addr = 3'd2; sw_wdata = '0; ev_ov = 1;
    tick; sw_we = 0; ev_ov = 0;
    rd(2, v); chk("R9 event beats software clear", v, 1);
    ack = 1; ack_vec = 3'd0; ev_ov = 1; tick; ack = 0; ev_ov = 0;
    rd(2, v); chk("R9 event beats ack clear", v, 1);
    clear_all;

    // R7 R8 grouped member and acknowledge
    wr(0, 1); wr(3, 1); wr(5, 1);
    tmr_match_a[0] = 1; tick; tmr_match_a[0] = 0;
    rd(6, v); chk("R7 member flag set", v, 1);
    rd(4, v); chk("R7 group flag set", v, 1);
    chk("R10 wake on timer event", int'(wake), 1);
    chk("R7 group request", int'(irq_req), 1);
    chk("R5 group vector", int'(irq_vec), 3);
    ack = 1; ack_vec = 3'd3; tick; ack = 0;
    rd(4, v); chk("R8 group flag cleared", v, 0);
    rd(6, v); chk("R8 member flag kept", v, 1);
    rd(0, v); chk("R6 global enable cleared by group ack", v, 0);
    wr(0, 1); #0.1;
    chk("R8 no request without group flag", int'(irq_req), 0);
    tmr_match_p[1] = 1; tick; tmr_match_p[1] = 0;
    rd(6, v); chk("R7 disabled member still flagged", v, 9);
    rd(4, v); chk("R7 disabled member leaves group", v, 0);

    done = 1;
    summary;
  end
endmodule